// File: doc/BRIEF.md
# OSD Pixel Unpack and Blend Stage

This stage takes one on-screen-display word per cycle, together with the video pixel that belongs to the same screen position. It decodes the display pixel from that word. The decode is driven by two independent settings: the container size in bits per pixel, and the colour format. Indexed pixels are resolved through a 256-entry colour table. The stage then works out how transparent the pixel is, from three sources: a colour-key match, the pixel's own alpha and a global alpha. Last, it mixes the display colour over the video pixel one component at a time.

The colour table is loaded in two steps. Software first writes a table position and then writes a colour, which is stored at the position written before. Configuration is sampled together with each pixel, so a change takes effect from the next pixel presented. Components are 8 bits wide and are packed R in [23:16], G in [15:8] and B in [7:0], for video and output alike.

Top module: `osd_blend`

## Requirements
- R1: `out_valid` rises exactly three clock cycles after the cycle in which `in_valid` was high, with one output per input. During reset and right after it, `out_valid` is 0 and `out_px` is 0.
- R2: The bpp field decides how the colour format is chosen. The value 01 (8 bpp) forces the indexed decode, whatever the colour format field holds. The values 10 (16 bpp), 11 (32 bpp) and 00 (treated like 32) use the colour format field.
- R3: Reduced formats read only `osd_word[15:0]`, and bits [31:16] are padding with no effect. The field positions are: format 001 has R[15:11] G[10:5] B[4:0]; format 010 has R[14:10] G[9:5] B[4:0]; format 011 has R[11:8] G[7:4] B[3:0]. Each component is widened to 8 bits by appending copies of its own top bits.
- R4: Format 100 reads the word as A[31:24] R[23:16] G[15:8] B[7:0]. Format 101 (indexed) uses `osd_word[7:0]` as the table position and ignores bits [31:8]. Table entries use the same A/R/G/B layout.
- R5: A high `pal_idx_we` stores `pal_idx` as the pending position. A high `pal_col_we` writes `pal_col` into the table at the pending position held before that edge, which also applies when both strobes are high together. All table entries and the position reset to 0. A pixel presented in the cycle of a write sees the written colour.
- R6: When `cfg_key_en` is 1, a key match makes the pixel fully transparent, so the output equals the video pixel. Reduced formats compare `osd_word[15:0]` with `cfg_key[15:0]`. Format 100 compares all 32 bits. Indexed compares the 8-bit position with `cfg_key[7:0]`.
- R7: Per-pixel alpha (the A byte) is used only when `cfg_lalpha_en` is 1 and the format is 100 or indexed. Otherwise the per-pixel alpha is taken as 255.
- R8: The global alpha is `cfg_galpha` when `cfg_galpha_en` is 1, and 255 otherwise. The effective alpha is (local × global + 127) / 255, using integer division, so that all three transparency controls combine.
- R9: Each output component is (osd × a + video × (255 − a) + 127) / 255, using integer division. With a = 255 the output is the display colour, and with a = 0 it is the video colour.
- R10: With bpp 00, 10 or 11 and an undefined colour format (000, 110, 111), the effective alpha is 0 and the output equals the video pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Display word and video pixel are present |
| osd_word | input | 32 | Stored display pixel container |
| video_px | input | 24 | Co-timed video pixel, R/G/B |
| cfg_mode | input | 3 | Colour format select |
| cfg_bpp | input | 2 | Container size select |
| cfg_key_en | input | 1 | Colour-key enable |
| cfg_key | input | 32 | Colour-key value |
| cfg_lalpha_en | input | 1 | Per-pixel alpha enable |
| cfg_galpha_en | input | 1 | Global alpha enable |
| cfg_galpha | input | 8 | Global alpha value |
| pal_idx_we | input | 1 | Table position write strobe |
| pal_idx | input | 8 | Table position |
| pal_col_we | input | 1 | Table colour write strobe |
| pal_col | input | 32 | Table colour, A/R/G/B |
| out_valid | output | 1 | Blended pixel is present |
| out_px | output | 24 | Blended pixel, R/G/B |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a key match and a non-trivial per-pixel or global alpha on the same pixel. The bench provokes this by setting the key equal to a pixel that carries an alpha byte of, for example, 0x80 with global alpha enabled, and it expects the video pixel unchanged, because the key overrides the alpha. The second pair is a table write and an indexed pixel that reads the same position. The bench presents both in one cycle, and also a position write together with a colour write, and judges the output against a model that applies the colour to the old position before it resolves the pixel. A long mixed run then changes format, container size, enables and table contents at random, and the output is compared with the model on every cycle.

// File: rtl/osd_blend_pkg.sv
package osd_blend_pkg;

  localparam int COMP_W    = 8;
  localparam int PIX_W     = 3 * COMP_W;
  localparam int WORD_W    = 32;
  localparam int PAL_IDX_W = 8;

  typedef enum logic [2:0] {
    FMT_NONE = 3'd0,
    FMT_565  = 3'd1,
    FMT_555  = 3'd2,
    FMT_444  = 3'd3,
    FMT_8888 = 3'd4,
    FMT_IDX  = 3'd5
  } fmt_e;

  typedef struct packed {
    logic                 valid;
    logic                 indexed;
    logic                 alpha_ok;
    logic                 bad_fmt;
    logic                 key_hit;
    logic [WORD_W-1:0]    argb;
    logic [PAL_IDX_W-1:0] idx;
    logic [PIX_W-1:0]     video;
    logic                 lalpha_en;
    logic                 galpha_en;
    logic [COMP_W-1:0]    galpha;
  } s1_t;

  typedef struct packed {
    logic              valid;
    logic [PIX_W-1:0]  osd;
    logic [PIX_W-1:0]  video;
    logic [COMP_W-1:0] alpha;
  } s2_t;

  function automatic logic [7:0] widen5(input logic [4:0] x);
    return {x, x[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] x);
    return {x, x[5:4]};
  endfunction

  function automatic logic [7:0] widen4(input logic [3:0] x);
    return {x, x};
  endfunction

  function automatic logic [7:0] alpha_mul(input logic [7:0] la, input logic [7:0] ga);
    logic [16:0] p;
    p = 17'(la) * 17'(ga) + 17'd127;
    return 8'(p / 17'd255);
  endfunction

  function automatic logic [7:0] blend8(input logic [7:0] o, input logic [7:0] v,
                                        input logic [7:0] a);
    logic [16:0] s;
    s = 17'(o) * 17'(a) + 17'(v) * 17'(8'd255 - a) + 17'd127;
    return 8'(s / 17'd255);
  endfunction

endpackage

// File: rtl/osd_palette.sv
module osd_palette #(
  parameter int IDX_W = 8,
  parameter int COL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_we,
  input  logic [IDX_W-1:0] idx_in,
  input  logic             col_we,
  input  logic [COL_W-1:0] col_in,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [COL_W-1:0] rd_col
);
  localparam int DEPTH = 1 << IDX_W;

  logic [COL_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (col_we) mem[idx_q] <= col_in;
      if (idx_we) idx_q <= idx_in;
    end
  end

  assign rd_col = mem[rd_idx];

  AST_PAL_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    col_we |=> mem[$past(idx_q)] == $past(col_in)); // R5

endmodule

// File: rtl/osd_unpack.sv
module osd_unpack
  import osd_blend_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] osd_word,
  input  logic [PIX_W-1:0]  video_px,
  input  logic [2:0]        cfg_mode,
  input  logic [1:0]        cfg_bpp,
  input  logic              cfg_key_en,
  input  logic [WORD_W-1:0] cfg_key,
  input  logic              cfg_lalpha_en,
  input  logic              cfg_galpha_en,
  input  logic [COMP_W-1:0] cfg_galpha,
  output s1_t               s1_q
);
  fmt_e fmt;
  s1_t  nxt;
  logic forced_idx;

  assign forced_idx = in_valid && (cfg_bpp == 2'b01);

  always_comb begin
    fmt = (cfg_bpp == 2'b01) ? FMT_IDX : fmt_e'(cfg_mode);
    nxt           = '0;
    nxt.valid     = in_valid;
    nxt.video     = video_px;
    nxt.idx       = osd_word[PAL_IDX_W-1:0];
    nxt.lalpha_en = cfg_lalpha_en;
    nxt.galpha_en = cfg_galpha_en;
    nxt.galpha    = cfg_galpha;
    nxt.argb      = {8'hff, 24'h0};
    case (fmt)
      FMT_565: begin
        nxt.argb[23:0] = {widen5(osd_word[15:11]), widen6(osd_word[10:5]),
                          widen5(osd_word[4:0])};
        nxt.key_hit = osd_word[15:0] == cfg_key[15:0];
      end
      FMT_555: begin
        nxt.argb[23:0] = {widen5(osd_word[14:10]), widen5(osd_word[9:5]),
                          widen5(osd_word[4:0])};
        nxt.key_hit = osd_word[15:0] == cfg_key[15:0];
      end
      FMT_444: begin
        nxt.argb[23:0] = {widen4(osd_word[11:8]), widen4(osd_word[7:4]),
                          widen4(osd_word[3:0])};
        nxt.key_hit = osd_word[15:0] == cfg_key[15:0];
      end
      FMT_8888: begin
        nxt.argb     = osd_word;
        nxt.alpha_ok = 1'b1;
        nxt.key_hit  = osd_word == cfg_key;
      end
      FMT_IDX: begin
        nxt.indexed  = 1'b1;
        nxt.alpha_ok = 1'b1;
        nxt.key_hit  = osd_word[PAL_IDX_W-1:0] == cfg_key[PAL_IDX_W-1:0];
      end
      default: nxt.bad_fmt = 1'b1;
    endcase
    nxt.key_hit = nxt.key_hit && cfg_key_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) s1_q <= '0;
    else        s1_q <= nxt;
  end

  AST_FORCE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    forced_idx |=> s1_q.indexed && s1_q.idx == $past(osd_word[PAL_IDX_W-1:0])); // R2

endmodule

// File: rtl/osd_resolve.sv
module osd_resolve
  import osd_blend_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  s1_t                  s1,
  input  logic [WORD_W-1:0]    pal_col,
  output logic [PAL_IDX_W-1:0] pal_rd_idx,
  output s2_t                  s2_q
);
  logic [WORD_W-1:0] colour;
  logic [COMP_W-1:0] la, ga;
  logic              drop, plain;
  s2_t               nxt;

  assign pal_rd_idx = s1.idx;
  assign colour     = s1.indexed ? pal_col : s1.argb;
  assign la         = (s1.lalpha_en && s1.alpha_ok) ? colour[31:24] : 8'hff;
  assign ga         = s1.galpha_en ? s1.galpha : 8'hff;
  assign drop       = s1.valid && (s1.key_hit || s1.bad_fmt);
  assign plain      = s1.valid && !s1.key_hit && !s1.bad_fmt &&
                      !s1.lalpha_en && !s1.galpha_en;

  always_comb begin
    nxt.valid = s1.valid;
    nxt.osd   = colour[23:0];
    nxt.video = s1.video;
    nxt.alpha = (s1.key_hit || s1.bad_fmt) ? 8'h00 : alpha_mul(la, ga);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) s2_q <= '0;
    else        s2_q <= nxt;
  end

  AST_DROP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> s2_q.alpha == 8'h00); // R6
  AST_SOLID_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    plain |=> s2_q.alpha == 8'hff); // R8

endmodule

// File: rtl/osd_mix.sv
module osd_mix
  import osd_blend_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  s2_t              s2,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_px
);
  logic [PIX_W-1:0] mixed;
  logic             solid, clear;

  assign solid = s2.valid && s2.alpha == 8'hff;
  assign clear = s2.valid && s2.alpha == 8'h00;

  for (genvar c = 0; c < 3; c++) begin : g_comp
    assign mixed[c*COMP_W +: COMP_W] = blend8(s2.osd[c*COMP_W +: COMP_W],
                                              s2.video[c*COMP_W +: COMP_W], s2.alpha);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_px    <= '0;
    end else begin
      out_valid <= s2.valid;
      if (s2.valid) out_px <= mixed;
    end
  end

  AST_OPAQUE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    solid |=> out_px == $past(s2.osd)); // R9
  AST_CLEAR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> out_px == $past(s2.video)); // R9

endmodule

// File: rtl/osd_blend.sv
module osd_blend
  import osd_blend_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] osd_word,
  input  logic [23:0] video_px,
  input  logic [2:0]  cfg_mode,
  input  logic [1:0]  cfg_bpp,
  input  logic        cfg_key_en,
  input  logic [31:0] cfg_key,
  input  logic        cfg_lalpha_en,
  input  logic        cfg_galpha_en,
  input  logic [7:0]  cfg_galpha,
  input  logic        pal_idx_we,
  input  logic [7:0]  pal_idx,
  input  logic        pal_col_we,
  input  logic [31:0] pal_col,
  output logic        out_valid,
  output logic [23:0] out_px
);
  s1_t                  s1;
  s2_t                  s2;
  logic [PAL_IDX_W-1:0] rd_idx;
  logic [WORD_W-1:0]    rd_col;

  osd_palette #(.IDX_W(PAL_IDX_W), .COL_W(WORD_W)) u_pal (
    .clk(clk), .rst_n(rst_n), .idx_we(pal_idx_we), .idx_in(pal_idx),
    .col_we(pal_col_we), .col_in(pal_col), .rd_idx(rd_idx), .rd_col(rd_col)
  );

  osd_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .osd_word(osd_word),
    .video_px(video_px), .cfg_mode(cfg_mode), .cfg_bpp(cfg_bpp),
    .cfg_key_en(cfg_key_en), .cfg_key(cfg_key), .cfg_lalpha_en(cfg_lalpha_en),
    .cfg_galpha_en(cfg_galpha_en), .cfg_galpha(cfg_galpha), .s1_q(s1)
  );

  osd_resolve u_resolve (
    .clk(clk), .rst_n(rst_n), .s1(s1), .pal_col(rd_col),
    .pal_rd_idx(rd_idx), .s2_q(s2)
  );

  osd_mix u_mix (
    .clk(clk), .rst_n(rst_n), .s2(s2), .out_valid(out_valid), .out_px(out_px)
  );

  AST_LAT_S1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid == 1'b1 |=> s1.valid); // R1
  AST_LAT_S2: assert property (@(posedge clk) disable iff (!rst_n)
    s1.valid |=> s2.valid); // R1
  AST_LAT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    s2.valid |=> out_valid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !s2.valid |=> !out_valid); // R1

endmodule

// File: tb/osd_blend_tb_top.sv
`timescale 1ns/1ps
module osd_blend_tb_top;
  localparam real CLK_HALF = 4.0;
  localparam int  WATCHDOG = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] osd_word = '0;
  logic [23:0] video_px = '0;
  logic [2:0]  cfg_mode = '0;
  logic [1:0]  cfg_bpp = '0;
  logic        cfg_key_en = 1'b0;
  logic [31:0] cfg_key = '0;
  logic        cfg_lalpha_en = 1'b0;
  logic        cfg_galpha_en = 1'b0;
  logic [7:0]  cfg_galpha = '0;
  logic        pal_idx_we = 1'b0;
  logic [7:0]  pal_idx = '0;
  logic        pal_col_we = 1'b0;
  logic [31:0] pal_col = '0;
  logic        out_valid;
  logic [23:0] out_px;

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string cur_tag = "R1";

  logic [31:0] pal_m [256];
  logic [7:0]  idx_m = '0;
  bit          ev [3];
  logic [23:0] epx [3];
  string       etag [3];

  always #(CLK_HALF) clk = ~clk;

  osd_blend dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .osd_word(osd_word),
    .video_px(video_px), .cfg_mode(cfg_mode), .cfg_bpp(cfg_bpp),
    .cfg_key_en(cfg_key_en), .cfg_key(cfg_key), .cfg_lalpha_en(cfg_lalpha_en),
    .cfg_galpha_en(cfg_galpha_en), .cfg_galpha(cfg_galpha),
    .pal_idx_we(pal_idx_we), .pal_idx(pal_idx), .pal_col_we(pal_col_we),
    .pal_col(pal_col), .out_valid(out_valid), .out_px(out_px)
  );

  function automatic int rep(input int v, input int bits);
    int r;
    r = v << (8 - bits);
    r = r | (v >> (2 * bits - 8));
    return r & 255;
  endfunction

  function automatic logic [23:0] model_px();
    int w, k, fm, r, g, b, la, ga, a, idx;
    int o[3], v[3], res[3];
    bit hit, aok, bad;
    w = int'(osd_word); k = int'(cfg_key);
    fm = (cfg_bpp == 2'b01) ? 5 : int'(cfg_mode);
    hit = 0; aok = 0; bad = 0; la = 255; r = 0; g = 0; b = 0;
    case (fm)
      1: begin r = rep((w >> 11) & 31, 5); g = rep((w >> 5) & 63, 6); b = rep(w & 31, 5);
               hit = (w & 65535) == (k & 65535); end
      2: begin r = rep((w >> 10) & 31, 5); g = rep((w >> 5) & 31, 5); b = rep(w & 31, 5);
               hit = (w & 65535) == (k & 65535); end
      3: begin r = ((w >> 8) & 15) * 17; g = ((w >> 4) & 15) * 17; b = (w & 15) * 17;
               hit = (w & 65535) == (k & 65535); end
      4: begin la = (w >> 24) & 255; r = (w >> 16) & 255; g = (w >> 8) & 255; b = w & 255;
               aok = 1; hit = osd_word == cfg_key; end
      5: begin idx = w & 255; la = int'(pal_m[idx][31:24]); r = int'(pal_m[idx][23:16]);
               g = int'(pal_m[idx][15:8]); b = int'(pal_m[idx][7:0]);
               aok = 1; hit = idx == (k & 255); end
      default: bad = 1;
    endcase
    if (!(cfg_lalpha_en && aok)) la = 255;
    ga = cfg_galpha_en ? int'(cfg_galpha) : 255;
    a = (la * ga + 127) / 255;
    if ((cfg_key_en && hit) || bad) a = 0;
    o[2] = r; o[1] = g; o[0] = b;
    v[2] = int'(video_px[23:16]); v[1] = int'(video_px[15:8]); v[0] = int'(video_px[7:0]);
    for (int c = 0; c < 3; c++) res[c] = (o[c] * a + v[c] * (255 - a) + 127) / 255;
    return {res[2][7:0], res[1][7:0], res[0][7:0]};
  endfunction

  task automatic fail(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (pal_col_we) pal_m[idx_m] = pal_col;
    if (pal_idx_we) idx_m = pal_idx;
    ev[2] = ev[1]; epx[2] = epx[1]; etag[2] = etag[1];
    ev[1] = ev[0]; epx[1] = epx[0]; etag[1] = etag[0];
    ev[0] = in_valid; etag[0] = cur_tag;
    epx[0] = in_valid ? model_px() : 24'h0;
    #1;
    checks++;
    if (out_valid !== ev[2]) fail(etag[2], "out_valid", 32'(out_valid), 32'(ev[2]));
    else if (ev[2] && out_px !== epx[2]) fail(etag[2], "out_px", 32'(out_px), 32'(epx[2]));
    @(negedge clk);
    in_valid = 1'b0; pal_idx_we = 1'b0; pal_col_we = 1'b0;
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) step();
  endtask

  task automatic cfg(input logic [1:0] bpp, input logic [2:0] mode, input bit ken,
                     input logic [31:0] key, input bit len, input bit gen,
                     input logic [7:0] gal);
    cfg_bpp = bpp; cfg_mode = mode; cfg_key_en = ken; cfg_key = key;
    cfg_lalpha_en = len; cfg_galpha_en = gen; cfg_galpha = gal;
  endtask

  task automatic px(input logic [31:0] w, input logic [23:0] v);
    in_valid = 1'b1; osd_word = w; video_px = v;
    step();
  endtask

  task automatic pal_write(input logic [7:0] i, input logic [31:0] c);
    pal_idx_we = 1'b1; pal_idx = i;
    step();
    pal_col_we = 1'b1; pal_col = c;
    step();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) pal_m[i] = '0;
    for (int i = 0; i < 3; i++) begin ev[i] = 0; epx[i] = '0; etag[i] = "R1"; end
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || out_px !== 24'h0)
      fail("R1", "reset outputs", {7'd0, out_valid, out_px}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: latency with a solid 8888 pixel and gaps
    cur_tag = "R1";
    cfg(2'b11, 3'd4, 0, 32'h0, 0, 0, 8'h00);
    px(32'h00123456, 24'hffffff);
    step();
    px(32'h00abcdef, 24'h000000);
    flush();

    // R5: table load, then read back through indexed pixels
    cur_tag = "R5";
    pal_write(8'd3, 32'hff102030);
    pal_write(8'd200, 32'h80c0c0c0);
    pal_write(8'd255, 32'hffa0b0c0);
    cfg(2'b11, 3'd5, 0, 32'h0, 0, 0, 8'h00);
    px(32'h00000003, 24'h000000);
    px(32'h000000ff, 24'h111111);
    flush();
    // R5: both strobes together: colour goes to the old position (255)
    pal_idx_we = 1'b1; pal_idx = 8'd7; pal_col_we = 1'b1; pal_col = 32'hff445566;
    step();
    px(32'h000000ff, 24'h000000);
    px(32'h00000007, 24'h0a0a0a);
    flush();
    // R5: write and indexed read of the same position in one cycle
    pal_col_we = 1'b1; pal_col = 32'hff778899;
    px(32'h00000007, 24'h000000);
    flush();

    // R2: 8 bpp forces indexed regardless of format field
    cur_tag = "R2";
    cfg(2'b01, 3'd1, 0, 32'h0, 0, 0, 8'h00);
    px(32'hffff0003, 24'h202020);
    cfg(2'b01, 3'd7, 0, 32'h0, 0, 0, 8'h00);
    px(32'h12345603, 24'h202020);
    cfg(2'b00, 3'd1, 0, 32'h0, 0, 0, 8'h00);
    px(32'h0000f81f, 24'h000000);
    flush();

    // R3: reduced formats with garbage padding
    cur_tag = "R3";
    cfg(2'b10, 3'd1, 0, 32'h0, 0, 0, 8'h00);
    px(32'hdead8410, 24'h000000);
    px(32'hbeef07e0, 24'h000000);
    cfg(2'b11, 3'd2, 0, 32'h0, 0, 0, 8'h00);
    px(32'h5a5afc1f, 24'h000000);
    cfg(2'b10, 3'd3, 0, 32'h0, 0, 0, 8'h00);
    px(32'hffff1a5f, 24'h000000);
    flush();

    // R4: 8888 and padded indexed words
    cur_tag = "R4";
    cfg(2'b11, 3'd4, 0, 32'h0, 0, 0, 8'h00);
    px(32'h40010203, 24'h999999);
    cfg(2'b11, 3'd5, 0, 32'h0, 0, 0, 8'h00);
    px(32'hffffffc8, 24'h000000);
    flush();

    // R6: key match in each format, and key with alpha in the same cycle
    cur_tag = "R6";
    cfg(2'b10, 3'd1, 1, 32'h1234f81f, 0, 0, 8'h00);
    px(32'h9999f81f, 24'h336699);
    px(32'h9999f81e, 24'h336699);
    cfg(2'b11, 3'd4, 1, 32'h80112233, 1, 1, 8'h90);
    px(32'h80112233, 24'h445566);
    px(32'h81112233, 24'h445566);
    cfg(2'b11, 3'd5, 1, 32'hffffffc8, 1, 1, 8'h90);
    px(32'h000000c8, 24'h0f0f0f);
    cfg(2'b11, 3'd3, 1, 32'h00000abc, 0, 1, 8'h40);
    px(32'h12340abc, 24'h778899);
    flush();

    // R7: local alpha only where the format carries it
    cur_tag = "R7";
    cfg(2'b11, 3'd4, 0, 32'h0, 1, 0, 8'h00);
    px(32'h80ff0000, 24'h0000ff);
    cfg(2'b10, 3'd1, 0, 32'h0, 1, 0, 8'h00);
    px(32'h0000f800, 24'h0000ff);
    cfg(2'b11, 3'd5, 0, 32'h0, 1, 0, 8'h00);
    px(32'h000000c8, 24'h000000);
    flush();

    // R8: global alpha alone and combined
    cur_tag = "R8";
    cfg(2'b11, 3'd4, 0, 32'h0, 0, 1, 8'h80);
    px(32'h00ffffff, 24'h000000);
    cfg(2'b11, 3'd4, 0, 32'h0, 1, 1, 8'h80);
    px(32'h80ffffff, 24'h000000);
    cfg(2'b11, 3'd4, 0, 32'h0, 1, 1, 8'h00);
    px(32'hffffffff, 24'h123456);
    flush();

    // R10: undefined formats
    cur_tag = "R10";
    cfg(2'b11, 3'd0, 0, 32'h0, 0, 0, 8'h00);
    px(32'hffffffff, 24'h5a5a5a);
    cfg(2'b10, 3'd6, 0, 32'h0, 0, 0, 8'h00);
    px(32'hffffffff, 24'ha5a5a5);
    cfg(2'b00, 3'd7, 0, 32'h0, 0, 0, 8'h00);
    px(32'hffffffff, 24'h010203);
    flush();

    // R9: mixed random stream including table writes
    cur_tag = "R9";
    for (int n = 0; n < 1500; n++) begin
      cfg(2'($urandom), 3'($urandom), 1'($urandom), ($urandom % 4 == 0) ? 32'h000000c8 : $urandom,
          1'($urandom), 1'($urandom), 8'($urandom));
      if ($urandom % 8 == 0) begin pal_idx_we = 1'b1; pal_idx = 8'($urandom % 16 + 192); end
      if ($urandom % 6 == 0) begin pal_col_we = 1'b1; pal_col = $urandom; end
      in_valid = ($urandom % 10) < 7;
      osd_word = ($urandom % 3 == 0) ? (32'($urandom) & 32'hffffff00) | 32'($urandom % 16 + 192)
                                      : $urandom;
      video_px = 24'($urandom);
      step();
    end
    flush();

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=%h expected=%h", 32'h1, 32'h0);
      done = 1;
      summary();
      $finish;
    end
  end

endmodule